// File: doc/BRIEF.md
# Multicycle Arithmetic Execution Pair with Shared Result Broadcast

This block holds two non-pipelined execution units. One is an add/subtract unit. The other is a multiply/divide unit. Each unit takes one operation at a time through its own issue port. An operation consists of a 2-bit opcode, two operand values and the nonzero tag of the station that issued it. The unit stays occupied for a fixed number of cycles that depends on the operation class. It then broadcasts the result, together with the issuing tag, on a single result bus. Integer arithmetic stands in for the floating-point datapath.

Execution counts the issue cycle as its first cycle. The broadcast appears during the last execution cycle, so a consumer that matches the tag can start on the next cycle. A fixed-priority arbiter owns the result bus. When both units finish in the same cycle, the multiply/divide unit wins. The add unit keeps its result and tries again on the following cycle. Upstream logic issues only while a unit reports ready, and it must hold a request that was not taken.

Top module: `exu_bcast_pair`

## Requirements
- R1: Opcodes are encoded as 2'b00 add, 2'b01 subtract, 2'b10 multiply and 2'b11 divide. The add unit subtracts (a-b, modulo 2^32) for opcode 2'b01 and adds (a+b, modulo 2^32) for every other code.
- R2: An operation accepted by the add unit in cycle c is broadcast in cycle c+1, unless the bus is taken by the multiply/divide unit.
- R3: The multiply/divide unit treats every opcode other than 2'b11 as a multiply. A multiply accepted in cycle c broadcasts the low 32 bits of a*b in cycle c+2.
- R4: A divide (opcode 2'b11) accepted in cycle c broadcasts the unsigned quotient a/b in cycle c+11.
- R5: A divide by zero broadcasts all ones, with the same 12-cycle occupancy as any other divide.
- R6: A unit's ready output is high exactly when the unit is idle. It falls in the cycle after acceptance and rises in the cycle after that unit's broadcast. A divide therefore keeps ready low for 11 cycles.
- R7: A request made while the unit is busy is ignored. It produces no broadcast and does not change the pending result.
- R8: When both units finish in the same cycle, the bus carries the multiply/divide result. The add unit broadcasts its unchanged result and tag on the next cycle.
- R9: A request whose tag is zero is not accepted, and the unit stays ready. No broadcast ever carries tag zero.
- R10: After reset both units are ready and bus_valid is low. Whenever bus_valid is low, bus_tag and bus_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| add_req_valid | input | 1 | Issue request to the add unit |
| add_req_op | input | 2 | Opcode for the add unit |
| add_req_a | input | 32 | First operand for the add unit |
| add_req_b | input | 32 | Second operand for the add unit |
| add_req_tag | input | 4 | Issuing station tag (nonzero) |
| add_ready | output | 1 | Add unit idle and able to accept |
| mdv_req_valid | input | 1 | Issue request to the multiply/divide unit |
| mdv_req_op | input | 2 | Opcode for the multiply/divide unit |
| mdv_req_a | input | 32 | First operand (multiplicand or dividend) |
| mdv_req_b | input | 32 | Second operand (multiplier or divisor) |
| mdv_req_tag | input | 4 | Issuing station tag (nonzero) |
| mdv_ready | output | 1 | Multiply/divide unit idle and able to accept |
| bus_valid | output | 1 | A result is being broadcast this cycle |
| bus_tag | output | 4 | Tag of the producer of the broadcast result |
| bus_data | output | 32 | Broadcast result value |

## Verification
The assertions assume one thing about the requesters: an operation counts as issued only in a cycle where valid, ready and a nonzero tag are all present. The multiply-latency property also assumes the default latency parameters.

The stimulus keeps within these assumptions. The drivers sample ready away from the clock edge and raise valid only while the unit is idle. The two exceptions are deliberate probes: one pulses a request into a busy unit and one issues with tag zero, and both are expected to be dropped. The random mix varies gaps, opcodes and zero divisors, and it lines up completions so that the two units collide on the bus.

// File: rtl/exu_pkg.sv
package exu_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_DIV = 2'b11
    } exu_op_e;

endpackage

// File: rtl/exu_unit.sv
module exu_unit #(
    parameter int DW    = 32,
    parameter int TW    = 4,
    parameter int LAT_P = 2,   // latency of the primary operation
    parameter int LAT_S = 2,   // latency of the secondary operation
    parameter bit IS_MD = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [DW-1:0] req_a,
    input  logic [DW-1:0] req_b,
    input  logic [TW-1:0] req_tag,
    output logic          ready,
    output logic          done,
    output logic [TW-1:0] done_tag,
    output logic [DW-1:0] done_data,
    input  logic          grant
);
    import exu_pkg::*;

    localparam int LAT_MAX = (LAT_P > LAT_S) ? LAT_P : LAT_S;
    localparam int CW      = $clog2(LAT_MAX + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [TW-1:0] tag;
        logic [DW-1:0] res;
    } unit_st_t;

    unit_st_t      st_d, st_q;
    logic          sel_s;
    logic [DW-1:0] calc;
    logic          accept;

    generate
        if (IS_MD) begin : g_muldiv
            always_comb begin
                sel_s = (req_op == OP_DIV);
                if (sel_s) begin
                    calc = (req_b == '0) ? '1 : (req_a / req_b);
                end else begin
                    calc = req_a * req_b;
                end
            end
        end else begin : g_addsub
            always_comb begin
                sel_s = (req_op == OP_SUB);
                calc  = sel_s ? (req_a - req_b) : (req_a + req_b);
            end
        end
    endgenerate

    assign accept = req_valid && !st_q.busy && (req_tag != '0);
    assign done   = st_q.busy && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (done && grant) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.cnt  = sel_s ? CW'(LAT_S - 2) : CW'(LAT_P - 2);
            st_d.tag  = req_tag;
            st_d.res  = calc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready     = !st_q.busy;
    assign done_tag  = st_q.tag;
    assign done_data = st_q.res;

endmodule

// File: rtl/bcast_arb.sv
module bcast_arb #(
    parameter int N  = 2,
    parameter int DW = 32,
    parameter int TW = 4
) (
    input  logic [N-1:0]         req,
    input  logic [N-1:0][TW-1:0] tags,
    input  logic [N-1:0][DW-1:0] data,
    output logic [N-1:0]         grant,
    output logic                 bus_valid,
    output logic [TW-1:0]        bus_tag,
    output logic [DW-1:0]        bus_data
);
    // index 0 has the highest priority
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    always_comb begin
        bus_valid = |grant;
        bus_tag   = '0;
        bus_data  = '0;
        for (int i = 0; i < N; i++) begin
            bus_tag  = bus_tag  | (tags[i] & {TW{grant[i]}});
            bus_data = bus_data | (data[i] & {DW{grant[i]}});
        end
    end

endmodule

// File: rtl/exu_bcast_pair.sv
module exu_bcast_pair #(
    parameter int DW      = 32,
    parameter int TW      = 4,
    parameter int LAT_ADD = 2,
    parameter int LAT_MUL = 3,
    parameter int LAT_DIV = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_req_valid,
    input  logic [1:0]    add_req_op,
    input  logic [DW-1:0] add_req_a,
    input  logic [DW-1:0] add_req_b,
    input  logic [TW-1:0] add_req_tag,
    output logic          add_ready,
    input  logic          mdv_req_valid,
    input  logic [1:0]    mdv_req_op,
    input  logic [DW-1:0] mdv_req_a,
    input  logic [DW-1:0] mdv_req_b,
    input  logic [TW-1:0] mdv_req_tag,
    output logic          mdv_ready,
    output logic          bus_valid,
    output logic [TW-1:0] bus_tag,
    output logic [DW-1:0] bus_data
);
    localparam int NU     = 2;
    localparam int IX_MDV = 0;   // highest bus priority
    localparam int IX_ADD = 1;

    logic [NU-1:0]         u_done;
    logic [NU-1:0]         u_grant;
    logic [NU-1:0][TW-1:0] u_tag;
    logic [NU-1:0][DW-1:0] u_data;

    exu_unit #(
        .DW(DW), .TW(TW), .LAT_P(LAT_MUL), .LAT_S(LAT_DIV), .IS_MD(1'b1)
    ) u_mdv (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (mdv_req_valid),
        .req_op    (mdv_req_op),
        .req_a     (mdv_req_a),
        .req_b     (mdv_req_b),
        .req_tag   (mdv_req_tag),
        .ready     (mdv_ready),
        .done      (u_done[IX_MDV]),
        .done_tag  (u_tag[IX_MDV]),
        .done_data (u_data[IX_MDV]),
        .grant     (u_grant[IX_MDV])
    );

    exu_unit #(
        .DW(DW), .TW(TW), .LAT_P(LAT_ADD), .LAT_S(LAT_ADD), .IS_MD(1'b0)
    ) u_add (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (add_req_valid),
        .req_op    (add_req_op),
        .req_a     (add_req_a),
        .req_b     (add_req_b),
        .req_tag   (add_req_tag),
        .ready     (add_ready),
        .done      (u_done[IX_ADD]),
        .done_tag  (u_tag[IX_ADD]),
        .done_data (u_data[IX_ADD]),
        .grant     (u_grant[IX_ADD])
    );

    bcast_arb #(.N(NU), .DW(DW), .TW(TW)) u_arb (
        .req       (u_done),
        .tags      (u_tag),
        .data      (u_data),
        .grant     (u_grant),
        .bus_valid (bus_valid),
        .bus_tag   (bus_tag),
        .bus_data  (bus_data)
    );

endmodule

// File: rtl/exu_bcast_pair_chk.sv
module exu_bcast_pair_chk #(
    parameter int DW = 32,
    parameter int TW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          add_req_valid,
    input logic [TW-1:0] add_req_tag,
    input logic          add_ready,
    input logic          mdv_req_valid,
    input logic [1:0]    mdv_req_op,
    input logic [TW-1:0] mdv_req_tag,
    input logic          mdv_ready,
    input logic          bus_valid,
    input logic [TW-1:0] bus_tag,
    input logic [DW-1:0] bus_data
);
    import exu_pkg::*;

    logic add_take, mdv_take;
    assign add_take = add_req_valid && add_ready && (add_req_tag != '0);
    assign mdv_take = mdv_req_valid && mdv_ready && (mdv_req_tag != '0);

    // R2
    add_next_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        add_take |=> bus_valid);

    // R3
    mul_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdv_take && mdv_req_op == OP_MUL) |=> ##1 (bus_valid && bus_tag == $past(mdv_req_tag, 2)));

    // R6
    add_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        add_take |=> !add_ready);

    // R6
    mdv_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdv_take |=> !mdv_ready);

    // R9
    tag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_tag != '0));

    // R10
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (bus_tag == '0 && bus_data == '0));

endmodule

bind exu_bcast_pair exu_bcast_pair_chk #(.DW(DW), .TW(TW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .add_req_valid (add_req_valid),
    .add_req_tag   (add_req_tag),
    .add_ready     (add_ready),
    .mdv_req_valid (mdv_req_valid),
    .mdv_req_op    (mdv_req_op),
    .mdv_req_tag   (mdv_req_tag),
    .mdv_ready     (mdv_ready),
    .bus_valid     (bus_valid),
    .bus_tag       (bus_tag),
    .bus_data      (bus_data)
);

// File: tb/exu_bcast_pair_tb.sv
module exu_bcast_pair_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        add_req_valid = 1'b0;
    logic [1:0]  add_req_op = '0;
    logic [31:0] add_req_a = '0;
    logic [31:0] add_req_b = '0;
    logic [3:0]  add_req_tag = '0;
    logic        add_ready;
    logic        mdv_req_valid = 1'b0;
    logic [1:0]  mdv_req_op = '0;
    logic [31:0] mdv_req_a = '0;
    logic [31:0] mdv_req_b = '0;
    logic [3:0]  mdv_req_tag = '0;
    logic        mdv_ready;
    logic        bus_valid;
    logic [3:0]  bus_tag;
    logic [31:0] bus_data;

    always #5 clk = ~clk;

    exu_bcast_pair u_dut (
        .clk(clk), .rst_n(rst_n),
        .add_req_valid(add_req_valid), .add_req_op(add_req_op),
        .add_req_a(add_req_a), .add_req_b(add_req_b),
        .add_req_tag(add_req_tag), .add_ready(add_ready),
        .mdv_req_valid(mdv_req_valid), .mdv_req_op(mdv_req_op),
        .mdv_req_a(mdv_req_a), .mdv_req_b(mdv_req_b),
        .mdv_req_tag(mdv_req_tag), .mdv_ready(mdv_ready),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int n_conflict = 0;
    int last_md = -10;

    // expected outstanding work per unit
    logic        ad_pend = 1'b0, md_pend = 1'b0;
    int          ad_cyc, md_cyc;
    logic [3:0]  ad_tag, md_tag;
    logic [31:0] ad_data, md_data;
    string       ad_req, md_req;
    logic        md_due, ad_due;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] model(input bit md, input logic [1:0] op,
                                         input logic [31:0] a, input logic [31:0] b);
        if (md) begin
            if (op == 2'b11) return (b == 32'd0) ? 32'hFFFF_FFFF : a / b;
            return a * b;
        end
        return (op == 2'b01) ? a - b : a + b;
    endfunction

    function automatic string req_of(input bit md, input logic [1:0] op, input logic [31:0] b);
        if (!md) return "R1";
        if (op != 2'b11) return "R3";
        return (b == 32'd0) ? "R5" : "R4";
    endfunction

    // bus monitor: an independent model of timing and arbitration
    always @(negedge clk) begin
        if (rst_n) begin
            md_due = md_pend && (md_cyc == cyc);
            ad_due = ad_pend && (ad_cyc <= cyc);
            if (md_due) begin
                chk(bus_valid && bus_tag == md_tag && bus_data == md_data, md_req,
                    {bus_valid, bus_tag, bus_data}, {1'b1, md_tag, md_data});
                md_pend = 1'b0;
                last_md = cyc;
                if (ad_due) n_conflict++;
            end else if (ad_due) begin
                chk(bus_valid && bus_tag == ad_tag && bus_data == ad_data, "R2",
                    {bus_valid, bus_tag, bus_data}, {1'b1, ad_tag, ad_data});
                if (cyc != ad_cyc)
                    chk(cyc == ad_cyc + 1 && last_md == cyc - 1, "R8", 64'(cyc), 64'(ad_cyc + 1));
                ad_pend = 1'b0;
            end else begin
                chk(!bus_valid, "R7 R9 no broadcast due", {bus_valid, bus_tag, bus_data}, 64'd0);
            end
        end
    end

    task automatic add_issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                             input logic [3:0] tag);
        while (!add_ready) @(negedge clk);
        add_req_valid = 1'b1; add_req_op = op; add_req_a = a; add_req_b = b; add_req_tag = tag;
        ad_tag = tag; ad_data = model(1'b0, op, a, b); ad_req = req_of(1'b0, op, b);
        ad_cyc = cyc + 1; ad_pend = 1'b1;
        @(negedge clk);
        add_req_valid = 1'b0;
    endtask

    task automatic mdv_issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                             input logic [3:0] tag);
        while (!mdv_ready) @(negedge clk);
        mdv_req_valid = 1'b1; mdv_req_op = op; mdv_req_a = a; mdv_req_b = b; mdv_req_tag = tag;
        md_tag = tag; md_data = model(1'b1, op, a, b); md_req = req_of(1'b1, op, b);
        md_cyc = cyc + ((op == 2'b11) ? 11 : 2); md_pend = 1'b1;
        @(negedge clk);
        mdv_req_valid = 1'b0;
    endtask

    task automatic settle();
        while (!(add_ready && mdv_ready && !ad_pend && !md_pend)) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        int c0;
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd20511);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(add_ready && mdv_ready, "R10", {add_ready, mdv_ready}, 2'b11);
        chk(!bus_valid && bus_tag == 0 && bus_data == 0, "R10", {bus_valid, bus_tag, bus_data}, 0);

        // R1 add, subtract with wrap
        add_issue(2'b00, 32'd5, 32'd7, 4'd1);
        add_issue(2'b01, 32'd3, 32'd5, 4'd2);
        add_issue(2'b11, 32'hFFFF_FFFF, 32'd2, 4'd3);
        settle();

        // R3 multiply, R4 divide
        mdv_issue(2'b10, 32'h0001_0001, 32'h0001_0003, 4'd4);
        mdv_issue(2'b11, 32'd100, 32'd7, 4'd5);
        settle();

        // R5 divide by zero and R6 ready window of a divide
        mdv_issue(2'b11, 32'd9, 32'd0, 4'd5);
        n = 1;
        chk(!mdv_ready, "R6", mdv_ready, 0);
        while (!mdv_ready) begin @(negedge clk); n++; end
        chk(n == 12, "R6", 64'(n), 64'd12);
        settle();

        // R7 request into a busy unit is dropped
        mdv_issue(2'b11, 32'd1000, 32'd10, 4'd4);
        mdv_req_valid = 1'b1; mdv_req_op = 2'b10; mdv_req_a = 32'd3;
        mdv_req_b = 32'd3; mdv_req_tag = 4'd5;
        @(negedge clk);
        mdv_req_valid = 1'b0;
        n = 2;
        while (!mdv_ready) begin @(negedge clk); n++; end
        chk(n == 12, "R7", 64'(n), 64'd12);
        settle();

        // R9 tag zero is refused
        add_req_valid = 1'b1; add_req_op = 2'b00; add_req_a = 32'd1;
        add_req_b = 32'd1; add_req_tag = 4'd0;
        @(negedge clk);
        add_req_valid = 1'b0;
        chk(add_ready, "R9", add_ready, 1);
        repeat (3) @(negedge clk);

        // R8 collision: multiply then add finish together
        c0 = n_conflict;
        mdv_issue(2'b10, 32'd6, 32'd7, 4'd4);
        add_issue(2'b00, 32'd40, 32'd2, 4'd2);
        chk(!add_ready, "R8", add_ready, 0);
        settle();
        chk(n_conflict == c0 + 1, "R8", 64'(n_conflict), 64'(c0 + 1));

        // random mix
        fork
            begin
                for (int i = 0; i < 400; i++) begin
                    repeat ($urandom_range(0, 3)) @(negedge clk);
                    add_issue(2'($urandom_range(0, 3)), $urandom, $urandom,
                              4'($urandom_range(1, 3)));
                end
            end
            begin
                for (int i = 0; i < 150; i++) begin
                    logic [1:0]  op;
                    logic [31:0] b;
                    op = ($urandom_range(0, 2) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
                    case ($urandom_range(0, 3))
                        0: b = 32'd0;
                        1: b = 32'($urandom_range(1, 20));
                        default: b = $urandom;
                    endcase
                    repeat ($urandom_range(0, 2)) @(negedge clk);
                    mdv_issue(op, $urandom, b, 4'($urandom_range(4, 5)));
                end
            end
        join
        settle();
        chk(!ad_pend && !md_pend, "R2", {ad_pend, md_pend}, 0);
        chk(n_conflict > c0 + 1, "R8", 64'(n_conflict), 64'(c0 + 2));

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule